// File: doc/BRIEF.md
# Byte-Serial Card FIFO Engine

This block sits between a bus-side word FIFO and a card data port that moves one byte at a time. The FIFO holds sixteen 32-bit words. In the card-to-host direction the engine collects bytes from the card, assembles them into words and pushes each word into the FIFO for the host to read. In the host-to-card direction the host writes words into the FIFO, and the engine pops them and sends them to the card one byte per cycle.

Software first programs a transfer length in bytes. It then writes the control field with the enable bit set and the direction chosen. The engine counts the remaining bytes down to zero, raises its end flags, and switches itself off once the FIFO has also drained. A status vector shows the FIFO fill flags for the active direction only. An error strobe reports a push into a full FIFO and a pop from an empty one.

Top module: `byteFifoEngine`

## Requirements
- R1: After reset, `dataEnable` is 0, `bytesLeft` is 0, all 12 bits of `statusFlags` are 0, `cardRdTake` and `cardWrValid` are 0, and `errStrobe` is 0.
- R2: A `ctrlWrEn` cycle with `ctrlWrData[0]`=1 does four things: it copies the last value written through `lenWrEn` into `bytesLeft`, it sets `dataEnable`, it takes the direction from `ctrlWrData[1]` (1 = card-to-host, 0 = host-to-card), and it clears both end flags (`statusFlags[1:0]`).
- R3: In card-to-host mode, bytes are packed little-endian. The first byte of a word lands in bits 7:0 and the fourth byte in bits 31:24. Each completed word is pushed into the FIFO.
- R4: In card-to-host mode, `cardRdTake` pulses only when three conditions hold: `bytesLeft` is nonzero, the FIFO is not full, and `cardRdReady` is 1. At most one byte is taken per cycle, and every byte taken lowers `bytesLeft` by one.
- R5: When `bytesLeft` reaches zero partway through a word, that partial word is still pushed, with its unfilled upper bytes set to zero.
- R6: In host-to-card mode, a byte moves on every cycle where `cardWrValid` and `cardWrReady` are both 1. Each word is sent least significant byte first, and the next word is popped only after all four bytes of the previous word have gone out.
- R7: Once `bytesLeft` is zero while enabled, `statusFlags[0]` (data end) and `statusFlags[1]` (block end) are set. `dataEnable` clears one cycle after `bytesLeft` is zero and the FIFO is empty.
- R8: While enabled, the group for the current direction is shown and the other group reads zero. Host-to-card uses bits 2 to 6: active, half-empty (occupancy 8 or less), full (16), empty (0), and data available (nonzero). Card-to-host uses bits 7 to 11: active, half-full (occupancy 8 or more), full, empty, and data available. Both groups are zero while disabled.
- R9: `hostRdData` is 0 whenever the FIFO is empty. A host write is ignored when `bytesLeft` is zero or the direction is card-to-host.
- R10: An attempted push into a full FIFO, or a host pop from an empty FIFO, leaves the FIFO contents and occupancy unchanged. It raises `errStrobe` for exactly the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lenWrEn | input | 1 | Write strobe for the transfer length |
| lenWrData | input | 16 | Transfer length in bytes |
| ctrlWrEn | input | 1 | Write strobe for the control field |
| ctrlWrData | input | 2 | Bit 0 enable/start, bit 1 direction (1 = card-to-host) |
| hostWrEn | input | 1 | Host write of one FIFO word |
| hostWrData | input | 32 | Word written by the host |
| hostRdEn | input | 1 | Host read; pops the head word |
| hostRdData | output | 32 | Head word, or 0 when the FIFO is empty |
| cardRdReady | input | 1 | Card has a byte available |
| cardRdByte | input | 8 | Byte offered by the card |
| cardRdTake | output | 1 | Byte is consumed at this clock edge |
| cardWrReady | input | 1 | Card accepts a byte |
| cardWrValid | output | 1 | A byte is offered to the card |
| cardWrByte | output | 8 | Byte offered to the card |
| dataEnable | output | 1 | Engine is enabled |
| bytesLeft | output | 16 | Remaining byte count |
| statusFlags | output | 12 | End flags and direction-filtered FIFO flags |
| errStrobe | output | 1 | One-cycle overflow/underflow pulse |

## Verification
Host writes, host reads and control writes act at the clock edge where their strobe is sampled. `statusFlags`, `bytesLeft` and `errStrobe` therefore change right after that edge, and the bench reads them at the following falling edge. Card bytes move one per cycle, so after a start the bench waits a fixed number of cycles (transfer length plus a margin) before checking counts and flags. The end flags and the auto-disable each take one more register stage, so the bench checks them a cycle after the count or occupancy reaches zero. Bytes sent to the card and words read by the host are sampled 1 ns before the edge that consumes them, and are compared in order against queues the driver filled from the programmed pattern.

// File: rtl/byteFifoPkg.sv
package byteFifoPkg;
  parameter int WordW        = 32;
  parameter int BytesPerWord = WordW / 8;
  parameter int GroupW       = 5;

  typedef struct packed {
    logic             push;
    logic             pop;
    logic [WordW-1:0] pushData;
  } fifoStrobes_t;
endpackage

// File: rtl/fifoWordStore.sv
module fifoWordStore
  import byteFifoPkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  fifoStrobes_t          strobes,
  input  logic                  engActive,
  input  logic                  dirRx,
  output logic [WordW-1:0]      headWord,
  output logic                  fifoFull,
  output logic                  fifoEmpty,
  output logic [2*GroupW-1:0]   groupFlags,
  output logic                  errStrobe
);
  localparam int PtrW = $clog2(DEPTH);
  localparam int CntW = $clog2(DEPTH + 1);
  localparam logic [CntW-1:0] HalfMark = CntW'(DEPTH / 2);
  localparam logic [CntW-1:0] FullMark = CntW'(DEPTH);

  logic [WordW-1:0] memWords [DEPTH];
  logic [PtrW-1:0]  rdPtr;
  logic [PtrW-1:0]  wrPtr;
  logic [CntW-1:0]  occ;
  logic             doPush;
  logic             doPop;
  logic [GroupW-1:0] grp;

  assign fifoFull  = (occ == FullMark);
  assign fifoEmpty = (occ == '0);
  assign doPush    = strobes.push && !fifoFull;
  assign doPop     = strobes.pop && !fifoEmpty;
  assign wrPtr     = rdPtr + occ[PtrW-1:0];
  assign headWord  = memWords[rdPtr];

  always_ff @(posedge clk) begin
    if (doPush) memWords[wrPtr] <= strobes.pushData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdPtr     <= '0;
      occ       <= '0;
      errStrobe <= 1'b0;
    end else begin
      if (doPop) rdPtr <= rdPtr + 1'b1;
      occ       <= occ + CntW'(doPush) - CntW'(doPop);
      errStrobe <= (strobes.push && fifoFull) || (strobes.pop && fifoEmpty);
    end
  end

  // group bit order, low to high: active, half mark, full, empty, available
  assign grp[0] = 1'b1;
  assign grp[1] = dirRx ? (occ >= HalfMark) : (occ <= HalfMark);
  assign grp[2] = fifoFull;
  assign grp[3] = fifoEmpty;
  assign grp[4] = !fifoEmpty;

  always_comb begin
    groupFlags = '0;
    if (engActive) begin
      if (dirRx) groupFlags[2*GroupW-1:GroupW] = grp;
      else       groupFlags[GroupW-1:0]        = grp;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    occ <= FullMark); // R10
  AST_FULL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.push && !strobes.pop && fifoFull) |=> (occ == $past(occ) && errStrobe)); // R10
  AST_EMPTY_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.pop && !strobes.push && fifoEmpty) |=> (occ == '0 && errStrobe)); // R10
endmodule

// File: rtl/fifoEngineCtrl.sv
module fifoEngineCtrl
  import byteFifoPkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lenWrEn,
  input  logic [LEN_W-1:0]  lenWrData,
  input  logic              ctrlWrEn,
  input  logic [1:0]        ctrlWrData,
  input  logic              hostWrEn,
  input  logic [WordW-1:0]  hostWrData,
  input  logic              hostRdEn,
  input  logic              cardRdReady,
  input  logic [7:0]        cardRdByte,
  output logic              cardRdTake,
  input  logic              cardWrReady,
  output logic              cardWrValid,
  output logic [7:0]        cardWrByte,
  input  logic              fifoFull,
  input  logic              fifoEmpty,
  input  logic [WordW-1:0]  headWord,
  output fifoStrobes_t      strobes,
  output logic              dataEn,
  output logic              dirRx,
  output logic              endFlag,
  output logic [LEN_W-1:0]  bytesLeft
);
  localparam int LaneW = $clog2(BytesPerWord);
  localparam logic [LaneW-1:0] LastLane = LaneW'(BytesPerWord - 1);

  logic [LEN_W-1:0] lenReg;
  logic [LaneW-1:0] laneCnt;
  logic [WordW-1:0] shiftReg;
  logic [WordW-1:0] mergedWord;
  logic countLeft, lastByte, sendByte, moveByte;
  logic engPush, engPop, hostPush, hostPop;

  assign countLeft   = (bytesLeft != '0);
  assign cardRdTake  = dataEn && dirRx && countLeft && !fifoFull && cardRdReady;
  assign cardWrValid = dataEn && !dirRx && countLeft && ((laneCnt != '0) || !fifoEmpty);
  assign sendByte    = cardWrValid && cardWrReady;
  assign moveByte    = cardRdTake || sendByte;
  assign cardWrByte  = (laneCnt != '0) ? shiftReg[7:0] : headWord[7:0];
  assign mergedWord  = shiftReg | (WordW'(cardRdByte) << {laneCnt, 3'b000});
  assign lastByte    = (laneCnt == LastLane) || (bytesLeft == LEN_W'(1));

  assign engPush  = cardRdTake && lastByte;
  assign engPop   = sendByte && (laneCnt == '0);
  assign hostPush = hostWrEn && countLeft && !dirRx;
  assign hostPop  = hostRdEn && !engPop;

  assign strobes.push     = engPush || hostPush;
  assign strobes.pop      = engPop || hostPop;
  assign strobes.pushData = engPush ? mergedWord : hostWrData;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lenReg    <= '0;
      bytesLeft <= '0;
      laneCnt   <= '0;
      shiftReg  <= '0;
      dataEn    <= 1'b0;
      dirRx     <= 1'b0;
      endFlag   <= 1'b0;
    end else begin
      if (lenWrEn) lenReg <= lenWrData;
      if (ctrlWrEn) begin
        dataEn <= ctrlWrData[0];
        dirRx  <= ctrlWrData[1];
        if (ctrlWrData[0]) begin
          bytesLeft <= lenReg;
          laneCnt   <= '0;
          shiftReg  <= '0;
          endFlag   <= 1'b0;
        end
      end else begin
        if (dataEn && !countLeft) begin
          endFlag <= 1'b1;
          if (fifoEmpty) dataEn <= 1'b0;
        end
        if (cardRdTake) begin
          shiftReg <= lastByte ? '0 : mergedWord;
          laneCnt  <= lastByte ? '0 : laneCnt + 1'b1;
        end else if (sendByte) begin
          if (laneCnt != '0) begin
            shiftReg <= shiftReg >> 8;
            laneCnt  <= laneCnt - 1'b1;
          end else begin
            shiftReg <= headWord >> 8;
            laneCnt  <= (bytesLeft == LEN_W'(1)) ? '0 : LastLane;
          end
        end
        if (moveByte) bytesLeft <= bytesLeft - 1'b1;
      end
    end
  end

  AST_TAKE_GATED: assert property (@(posedge clk) disable iff (!rstN)
    cardRdTake |-> (cardRdReady && !fifoFull && bytesLeft != '0)); // R4
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (moveByte && !ctrlWrEn) |=> (bytesLeft == $past(bytesLeft) - 1'b1)); // R4
  AST_AUTO_OFF: assert property (@(posedge clk) disable iff (!rstN)
    (dataEn && bytesLeft == '0 && fifoEmpty && !ctrlWrEn) |=> (!dataEn && endFlag)); // R7
  AST_ONE_SIDE: assert property (@(posedge clk) disable iff (!rstN)
    !(cardRdTake && cardWrValid)); // R6
endmodule

// File: rtl/byteFifoEngine.sv
module byteFifoEngine
  import byteFifoPkg::*;
#(
  parameter int DEPTH = 16,
  parameter int LEN_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lenWrEn,
  input  logic [LEN_W-1:0]  lenWrData,
  input  logic              ctrlWrEn,
  input  logic [1:0]        ctrlWrData,
  input  logic              hostWrEn,
  input  logic [WordW-1:0]  hostWrData,
  input  logic              hostRdEn,
  output logic [WordW-1:0]  hostRdData,
  input  logic              cardRdReady,
  input  logic [7:0]        cardRdByte,
  output logic              cardRdTake,
  input  logic              cardWrReady,
  output logic              cardWrValid,
  output logic [7:0]        cardWrByte,
  output logic              dataEnable,
  output logic [LEN_W-1:0]  bytesLeft,
  output logic [2*GroupW+1:0] statusFlags,
  output logic              errStrobe
);
  fifoStrobes_t strobes;
  logic fifoFull, fifoEmpty, dirRx, endFlag;
  logic [WordW-1:0] headWord;
  logic [2*GroupW-1:0] groupFlags;

  fifoEngineCtrl #(.LEN_W(LEN_W)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .lenWrEn(lenWrEn), .lenWrData(lenWrData),
    .ctrlWrEn(ctrlWrEn), .ctrlWrData(ctrlWrData),
    .hostWrEn(hostWrEn), .hostWrData(hostWrData), .hostRdEn(hostRdEn),
    .cardRdReady(cardRdReady), .cardRdByte(cardRdByte), .cardRdTake(cardRdTake),
    .cardWrReady(cardWrReady), .cardWrValid(cardWrValid), .cardWrByte(cardWrByte),
    .fifoFull(fifoFull), .fifoEmpty(fifoEmpty), .headWord(headWord),
    .strobes(strobes), .dataEn(dataEnable), .dirRx(dirRx),
    .endFlag(endFlag), .bytesLeft(bytesLeft)
  );

  fifoWordStore #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .engActive(dataEnable), .dirRx(dirRx),
    .headWord(headWord), .fifoFull(fifoFull), .fifoEmpty(fifoEmpty),
    .groupFlags(groupFlags), .errStrobe(errStrobe)
  );

  assign hostRdData  = fifoEmpty ? '0 : headWord;
  assign statusFlags = {groupFlags, endFlag, endFlag};
endmodule

// File: tb/byteFifoEngine_bench.sv
module byteFifoEngine_bench;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rstN, lenWrEn, ctrlWrEn, hostWrEn, hostRdEn;
  logic [15:0] lenWrData;
  logic [1:0]  ctrlWrData;
  logic [31:0] hostWrData, hostRdData;
  logic        cardRdReady, cardRdTake, cardWrReady, cardWrValid;
  logic [7:0]  cardRdByte, cardWrByte;
  logic        dataEnable, errStrobe;
  logic [15:0] bytesLeft;
  logic [11:0] statusFlags;

  byteFifoEngine u_byteFifoEngine (
    .clk(clk), .rstN(rstN), .lenWrEn(lenWrEn), .lenWrData(lenWrData),
    .ctrlWrEn(ctrlWrEn), .ctrlWrData(ctrlWrData),
    .hostWrEn(hostWrEn), .hostWrData(hostWrData),
    .hostRdEn(hostRdEn), .hostRdData(hostRdData),
    .cardRdReady(cardRdReady), .cardRdByte(cardRdByte), .cardRdTake(cardRdTake),
    .cardWrReady(cardWrReady), .cardWrValid(cardWrValid), .cardWrByte(cardWrByte),
    .dataEnable(dataEnable), .bytesLeft(bytesLeft),
    .statusFlags(statusFlags), .errStrobe(errStrobe)
  );

  int testsRun = 0;
  int testsFailed = 0;
  logic [31:0] rxExp[$];
  logic [7:0]  txExp[$];
  int rxBase = 0;
  int rdIdx = 0;

  // card source model: byte value follows the take count
  assign cardRdByte = 8'h10 + rdIdx[7:0];
  always @(posedge clk) if (cardRdTake) rdIdx <= rdIdx + 1;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic setLen(input logic [15:0] v);
    lenWrData = v; lenWrEn = 1'b1; @(negedge clk); lenWrEn = 1'b0;
  endtask

  task automatic startXfer(input logic dir);
    ctrlWrData = {dir, 1'b1}; ctrlWrEn = 1'b1; @(negedge clk); ctrlWrEn = 1'b0;
  endtask

  task automatic hostWrite(input logic [31:0] w);
    hostWrData = w; hostWrEn = 1'b1; @(negedge clk); hostWrEn = 1'b0;
  endtask

  task automatic readWord(output logic [31:0] d);
    hostRdEn = 1'b1; #9 d = hostRdData; @(negedge clk); hostRdEn = 1'b0;
  endtask

  task automatic readCheck(input string req);
    logic [31:0] d;
    readWord(d);
    if (rxExp.size() == 0) check({req, " unexpected word"}, d, 32'hFFFF_FFFF);
    else check(req, d, rxExp.pop_front());
  endtask

  // driver side of the scoreboard: expected words, little-endian, zero-padded
  task automatic expectRx(input int n);
    logic [31:0] w;
    for (int i = 0; i < n; i += 4) begin
      w = '0;
      for (int b = 0; b < 4 && i + b < n; b++)
        w[8*b +: 8] = 8'h10 + 8'(rxBase + i + b);
      rxExp.push_back(w);
    end
    rxBase += n;
  endtask

  task automatic expectTxWord(input logic [31:0] w);
    for (int b = 0; b < 4; b++) txExp.push_back(w[8*b +: 8]);
  endtask

  function automatic logic [31:0] txWord(input int i);
    return 32'h5A00_0000 + (i << 16) + ((i * 3) << 8) + i;
  endfunction

  // monitor for bytes leaving towards the card
  initial forever begin
    @(negedge clk); #9;
    if (rstN === 1'b1 && cardWrValid && cardWrReady) begin
      if (txExp.size() == 0) check("R6 unexpected card byte", {24'd0, cardWrByte}, 32'hFFFF_FFFF);
      else check("R6 card byte order", {24'd0, cardWrByte}, {24'd0, txExp.pop_front()});
    end
  end

  task automatic summary;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
  endtask

  initial begin
    #(20 * 150000);
    testsFailed++;
    $display("FAIL watchdog: actual hung expected finished");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] d;
    rstN = 1'b0; lenWrEn = 0; ctrlWrEn = 0; hostWrEn = 0; hostRdEn = 0;
    lenWrData = '0; ctrlWrData = '0; hostWrData = '0;
    cardRdReady = 0; cardWrReady = 0;
    cyc(3);
    rstN = 1'b1;
    check("R1 dataEnable", {31'd0, dataEnable}, 32'd0);
    check("R1 bytesLeft", {16'd0, bytesLeft}, 32'd0);
    check("R1 statusFlags", {20'd0, statusFlags}, 32'd0);
    check("R1 card strobes", {30'd0, cardRdTake, cardWrValid}, 32'd0);
    check("R1 errStrobe", {31'd0, errStrobe}, 32'd0);

    // R9/R10: read of an empty FIFO
    readWord(d);
    check("R9 empty read data", d, 32'd0);
    check("R10 underflow strobe", {31'd0, errStrobe}, 32'd1);
    cyc(1);
    check("R10 strobe one cycle", {31'd0, errStrobe}, 32'd0);

    // R3/R5: card-to-host, 10 bytes
    setLen(16'd10); cardRdReady = 1'b1; startXfer(1'b1); expectRx(10);
    cyc(14);
    check("R4 count done", {16'd0, bytesLeft}, 32'd0);
    check("R8 R7 rx flags with 3 words", {20'd0, statusFlags}, 32'h883);
    check("R7 still enabled", {31'd0, dataEnable}, 32'd1);
    readCheck("R3 word0"); readCheck("R3 word1"); readCheck("R5 partial word");
    cyc(1);
    check("R7 auto off", {31'd0, dataEnable}, 32'd0);
    check("R8 groups zero when off", {20'd0, statusFlags}, 32'h003);

    // R4: ready gating
    cardRdReady = 1'b0; setLen(16'd4); startXfer(1'b1);
    check("R2 load and end flags cleared", {20'd0, statusFlags}, 32'h480);
    check("R2 bytesLeft loaded", {16'd0, bytesLeft}, 32'd4);
    cyc(4);
    check("R4 no take without ready", {16'd0, bytesLeft}, 32'd4);
    cardRdReady = 1'b1; expectRx(4); cyc(6);
    readCheck("R3 gated word");
    cyc(1);
    check("R7 off after gated", {31'd0, dataEnable}, 32'd0);

    // R4/R8: full FIFO stops intake
    setLen(16'd72); startXfer(1'b1); expectRx(72);
    cyc(80);
    check("R4 stalled on full", {16'd0, bytesLeft}, 32'd8);
    check("R8 rx full flags", {20'd0, statusFlags}, 32'hB80);
    cardRdReady = 1'b0;
    for (int i = 0; i < 8; i++) readCheck("R3 full drain");
    check("R8 half-full at 8", {31'd0, statusFlags[8]}, 32'd1);
    readCheck("R3 full drain");
    check("R8 rx flags at 7", {20'd0, statusFlags}, 32'h880);
    for (int i = 0; i < 7; i++) readCheck("R3 full drain");
    cardRdReady = 1'b1; cyc(12);
    readCheck("R4 resumed word"); readCheck("R4 resumed word");
    cyc(1);
    check("R7 off after long rx", {31'd0, dataEnable}, 32'd0);

    // R6/R8/R10: host-to-card
    cardWrReady = 1'b0; setLen(16'd40); startXfer(1'b0);
    for (int i = 0; i < 8; i++) hostWrite(txWord(i));
    check("R8 tx half-empty at 8", {20'd0, statusFlags}, 32'h04C);
    hostWrite(txWord(8));
    check("R8 tx at 9", {20'd0, statusFlags}, 32'h044);
    for (int i = 9; i < 16; i++) hostWrite(txWord(i));
    check("R8 tx full", {20'd0, statusFlags}, 32'h054);
    check("R10 no error before overflow", {31'd0, errStrobe}, 32'd0);
    hostWrite(32'hBAD0_BAD0);
    check("R10 overflow strobe", {31'd0, errStrobe}, 32'd1);
    check("R10 still full", {20'd0, statusFlags}, 32'h054);
    for (int i = 0; i < 10; i++) expectTxWord(txWord(i));
    for (int i = 10; i < 16; i++) rxExp.push_back(txWord(i));
    cardWrReady = 1'b1;
    cyc(45);
    check("R6 count done", {16'd0, bytesLeft}, 32'd0);
    check("R7 enabled while FIFO holds words", {31'd0, dataEnable}, 32'd1);
    check("R7 R8 tx flags with 6 words", {20'd0, statusFlags}, 32'h04F);
    check("R6 all bytes sent", txExp.size(), 32'd0);
    for (int i = 0; i < 6; i++) readCheck("R10 leftover words intact");
    cyc(1);
    check("R7 off after tx drain", {31'd0, dataEnable}, 32'd0);

    // R9: write ignored with zero count
    hostWrite(32'hDEAD_BEEF);
    cardWrReady = 1'b0; setLen(16'd4); startXfer(1'b0);
    check("R9 ignored write left FIFO empty", {20'd0, statusFlags}, 32'h02C);
    hostWrite(32'hA1B2_C3D4); expectTxWord(32'hA1B2_C3D4);
    cardWrReady = 1'b1; cyc(8);
    check("R6 short word sent", txExp.size(), 32'd0);
    check("R7 off after short tx", {31'd0, dataEnable}, 32'd0);

    // R7: zero length
    setLen(16'd0); startXfer(1'b1); cyc(2);
    check("R7 zero length off", {31'd0, dataEnable}, 32'd0);
    check("R7 zero length end flags", {20'd0, statusFlags}, 32'h003);
    check("R9 no leftover expected words", rxExp.size(), 32'd0);

    summary();
    $finish;
  end
endmodule